// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Unit

The block is a bank of countdown timers that share one prescaler. The prescaler is a 16-bit down-counter with its own reload value. Each time it passes zero it sends a single-cycle tick to every channel and starts again from its reload value. The tick rate is therefore the clock rate divided by the reload value plus one.

Each channel has a 32-bit counter, a 32-bit reload register and a small control register. An enabled channel counts down one step on each tick. It underflows on the tick that finds it at zero. At underflow it can raise its own interrupt line, record a sticky pending flag, and either reload its counter or switch itself off.

Software reaches every register through a simple 32-bit word bus with combinational read data. The map has a unit window at the bottom and one 16-byte window per channel above it. A read-only capability word reports the channel count, the base interrupt number and two feature flags. The number of channels (1 to 8) and the base interrupt number are parameters, and both are checked when the design is elaborated.

Top module: `mtimer_unit`

## Requirements
- R1: After reset, the prescaler value and reload read zero, every channel register reads zero and every interrupt line is low; with the reload at zero a tick is issued on every clock.
- R2: Offset 0x08 returns a read-only capability word: bits [2:0] hold the channel count (modulo 8), bits [7:3] the base interrupt number, and bits 8 and 9 are set. Writes to it have no effect.
- R3: Offset 0x00 holds the prescaler value and offset 0x04 the prescaler reload; both keep only the low 16 bits of a write and read with the upper 16 bits zero.
- R4: At each clock edge where the prescaler value is zero, a tick is issued and the value is reloaded; otherwise the value decreases by one. The tick period is therefore reload+1 clocks.
- R5: Channel n occupies bytes 0x10*(n+1) to 0x10*(n+1)+0xF, with the counter at +0x0, the reload at +0x4 and the control at +0x8. The counter and reload are full 32-bit read/write registers.
- R6: Reads from undefined offsets, non-word-aligned addresses or channels that do not exist return zero, and writes to them change nothing.
- R7: Control bits: bit 0 enable, bit 1 auto-restart, bit 2 load (counter takes the reload value; always reads 0), bit 3 interrupt enable, bit 4 pending. All other bits read 0.
- R8: An enabled channel decreases its counter by one on each tick and underflows on the tick that finds it at zero, so a start value K underflows on the (K+1)th tick.
- R9: At underflow with auto-restart clear, the channel clears its enable bit and stops.
- R10: At underflow with auto-restart set, the counter reloads, so the channel underflows every (K+1)*(P+1) clocks for reload K and prescaler reload P.
- R11: At underflow with interrupt enable set, the channel raises only its own interrupt line for one clock and sets pending. Pending is cleared only by a control write with bit 4 set; a control write with bit 4 clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one 32-bit word |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
The bench builds the unit with three channels and a base interrupt number of 5. A count that is not a power of two leaves the fourth channel window inside the decoded address range but without a channel, so the nonexistent-channel path can be probed next to real ones. The small prescaler and counter values make it practical to sweep every pairing of prescaler reload 0..3 and channel reload 0..3, spread across all three channels. Each measured interrupt period is compared against (K+1)*(P+1).

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

   localparam int DATA_W = 32;

   // unit window offsets
   localparam logic [3:0] OFF_PVAL = 4'h0;
   localparam logic [3:0] OFF_PRLD = 4'h4;
   localparam logic [3:0] OFF_CAPS = 4'h8;

   // channel window offsets
   localparam logic [3:0] OFF_CCNT = 4'h0;
   localparam logic [3:0] OFF_CRLD = 4'h4;
   localparam logic [3:0] OFF_CCTL = 4'h8;

   // control bit positions
   localparam int CB_EN   = 0;
   localparam int CB_AUTO = 1;
   localparam int CB_LOAD = 2;
   localparam int CB_IE   = 3;
   localparam int CB_PEND = 4;
   localparam int CTL_W   = 5;

   // capability flags
   localparam int CAPF_SEPIRQ = 8;
   localparam int CAPF_NOFRZ  = 9;

   function automatic logic [DATA_W-1:0] caps_word(input int nch, input int irq_base);
      logic [DATA_W-1:0] w;
      w = '0;
      w[2:0] = 3'(nch % 8);
      w[7:3] = 5'(irq_base);
      w[CAPF_SEPIRQ] = 1'b1;
      w[CAPF_NOFRZ]  = 1'b1;
      return w;
   endfunction

endpackage

// File: rtl/mtimer_prescaler.sv
module mtimer_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_val,
   input  logic             wr_rld,
   input  logic [PRE_W-1:0] wdata,
   output logic [PRE_W-1:0] val_q,
   output logic [PRE_W-1:0] rld_q,
   output logic             tick
);

   assign tick = (val_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         rld_q <= '0;
      end else begin
         if (wr_rld) rld_q <= wdata;
         if (wr_val)    val_q <= wdata;
         else if (tick) val_q <= rld_q;
         else           val_q <= val_q - 1'b1;
      end
   end

endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel
   import mtimer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               wr_cnt,
   input  logic               wr_rld,
   input  logic               wr_ctl,
   input  logic [CNT_W-1:0]   wdata,
   output logic [CNT_W-1:0]   cnt_q,
   output logic [CNT_W-1:0]   rld_q,
   output logic [CTL_W-1:0]   ctl_view,
   output logic               irq_q
);

   logic en_q, auto_q, ie_q, pend_q;
   logic at_zero;

   assign at_zero = (cnt_q == '0);

   always_comb begin
      ctl_view          = '0;
      ctl_view[CB_EN]   = en_q;
      ctl_view[CB_AUTO] = auto_q;
      ctl_view[CB_IE]   = ie_q;
      ctl_view[CB_PEND] = pend_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rld_q  <= '0;
         en_q   <= 1'b0;
         auto_q <= 1'b0;
         ie_q   <= 1'b0;
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (wr_rld) rld_q <= wdata;
         if (wr_ctl) begin
            en_q   <= wdata[CB_EN];
            auto_q <= wdata[CB_AUTO];
            ie_q   <= wdata[CB_IE];
            if (wdata[CB_PEND]) pend_q <= 1'b0;
            if (wdata[CB_LOAD]) cnt_q  <= rld_q;
         end else if (wr_cnt) begin
            cnt_q <= wdata;
         end else if (tick && en_q) begin
            if (at_zero) begin
               if (ie_q) begin
                  pend_q <= 1'b1;
                  irq_q  <= 1'b1;
               end
               if (auto_q) cnt_q <= rld_q;
               else        en_q  <= 1'b0;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
   import mtimer_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int IRQ_BASE = 8,
   parameter int PRE_W    = 16,
   parameter int CNT_W    = 32,
   parameter int ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_CH-1:0]   irq
);

   localparam logic [DATA_W-1:0] CAPS = caps_word(NUM_CH, IRQ_BASE);
   localparam int WIN_W = 4;

   // elaboration checks
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_nch
      $error("mtimer_unit: NUM_CH must be within 1..8");
   end
   if (IRQ_BASE < 0 || IRQ_BASE > 31) begin : g_bad_irqb
      $error("mtimer_unit: IRQ_BASE must fit in 5 bits");
   end
   if (PRE_W < 1 || PRE_W > 16) begin : g_bad_prew
      $error("mtimer_unit: PRE_W must be within 1..16");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cntw
      $error("mtimer_unit: CNT_W must be within 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("mtimer_unit: ADDR_W must be at least 8");
   end

   // address decode
   logic             hi_ok;
   logic [WIN_W-1:0] win;
   logic [3:0]       off;
   logic             unit_sel;

   if (ADDR_W > 8) begin : g_hi_chk
      assign hi_ok = ~|bus_addr[ADDR_W-1:8];
   end else begin : g_hi_none
      assign hi_ok = 1'b1;
   end

   assign win      = bus_addr[7:4];
   assign off      = bus_addr[3:0];
   assign unit_sel = hi_ok && (win == '0);

   // prescaler
   logic             pre_wr_val, pre_wr_rld, tick;
   logic [PRE_W-1:0] pre_val, pre_rld;

   assign pre_wr_val = bus_wr && unit_sel && (off == OFF_PVAL);
   assign pre_wr_rld = bus_wr && unit_sel && (off == OFF_PRLD);

   mtimer_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_val (pre_wr_val),
      .wr_rld (pre_wr_rld),
      .wdata  (bus_wdata[PRE_W-1:0]),
      .val_q  (pre_val),
      .rld_q  (pre_rld),
      .tick   (tick)
   );

   // channels
   logic [NUM_CH-1:0]              ch_sel;
   logic [NUM_CH-1:0]              ch_pend;
   logic [NUM_CH-1:0]              ch_en;
   logic [NUM_CH-1:0][DATA_W-1:0]  ch_rd;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CNT_W-1:0] cnt, rld;
      logic [CTL_W-1:0] ctl;
      logic             wr_c, wr_r, wr_k;

      assign ch_sel[i] = hi_ok && (win == WIN_W'(i + 1));
      assign wr_c = bus_wr && ch_sel[i] && (off == OFF_CCNT);
      assign wr_r = bus_wr && ch_sel[i] && (off == OFF_CRLD);
      assign wr_k = bus_wr && ch_sel[i] && (off == OFF_CCTL);

      mtimer_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .wr_cnt   (wr_c),
         .wr_rld   (wr_r),
         .wr_ctl   (wr_k),
         .wdata    (bus_wdata[CNT_W-1:0]),
         .cnt_q    (cnt),
         .rld_q    (rld),
         .ctl_view (ctl),
         .irq_q    (irq[i])
      );

      assign ch_pend[i] = ctl[CB_PEND];
      assign ch_en[i]   = ctl[CB_EN];

      always_comb begin
         ch_rd[i] = '0;
         if (ch_sel[i]) begin
            case (off)
               OFF_CCNT: ch_rd[i] = DATA_W'(cnt);
               OFF_CRLD: ch_rd[i] = DATA_W'(rld);
               OFF_CCTL: ch_rd[i] = DATA_W'(ctl);
               default:  ch_rd[i] = '0;
            endcase
         end
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (unit_sel) begin
         case (off)
            OFF_PVAL: bus_rdata = DATA_W'(pre_val);
            OFF_PRLD: bus_rdata = DATA_W'(pre_rld);
            OFF_CAPS: bus_rdata = CAPS;
            default:  bus_rdata = '0;
         endcase
      end
      for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rd[i];
   end

endmodule

// File: rtl/mtimer_unit_chk.sv
module mtimer_unit_chk
   import mtimer_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int IRQ_BASE = 8,
   parameter int PRE_W    = 16,
   parameter int ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_CH-1:0]   irq,
   input logic                tick,
   input logic [PRE_W-1:0]    pre_val,
   input logic [PRE_W-1:0]    pre_rld,
   input logic [NUM_CH-1:0]   ch_pend
);

   logic pv_wr;
   assign pv_wr = bus_wr && (bus_addr == ADDR_W'(0));

   assert_tick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !pv_wr) |=> (pre_val == $past(pre_rld)));

   assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !pv_wr) |=> (pre_val == $past(pre_val) - 1'b1));

   assert_caps_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8)) |-> (bus_rdata == caps_word(NUM_CH, IRQ_BASE)));

   assert_unaligned_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      assert_irq_sets_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> ch_pend[i]);
      assert_irq_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[i]) |-> $past(tick));
   end

endmodule

bind mtimer_unit mtimer_unit_chk #(
   .NUM_CH(NUM_CH), .IRQ_BASE(IRQ_BASE), .PRE_W(PRE_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .irq(irq), .tick(tick), .pre_val(pre_val),
   .pre_rld(pre_rld), .ch_pend(ch_pend)
);

// File: tb/sim_mtimer_unit.sv
`timescale 1ns/1ps
module sim_mtimer_unit;

   localparam int NCH = 3;
   localparam int IRQB = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] irq;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   mtimer_unit #(.NUM_CH(NCH), .IRQ_BASE(IRQB)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         n_tests = n_tests + 1;
         n_fail  = n_fail + 1;
         $display("FAIL watchdog: actual timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests = n_tests + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      int n;
      bit iso_bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, v); check("R1 pval", v, 0);
      rd(8'h04, v); check("R1 prld", v, 0);
      for (int c = 0; c < NCH; c++) begin
         rd(8'(16*(c+1)), v);     check("R1 ccnt", v, 0);
         rd(8'(16*(c+1) + 4), v); check("R1 crld", v, 0);
         rd(8'(16*(c+1) + 8), v); check("R1 cctl", v, 0);
      end
      check("R1 irq", 32'(irq), 0);

      // R2 capability word and read-only
      rd(8'h08, v); check("R2 caps", v, 32'(NCH) | (32'(IRQB) << 3) | 32'h300);
      wr(8'h08, 32'h0);
      rd(8'h08, v); check("R2 caps after write", v, 32'(NCH) | (32'(IRQB) << 3) | 32'h300);

      // R3 16-bit masking
      wr(8'h04, 32'h1234_5678);
      rd(8'h04, v); check("R3 prld mask", v, 32'h0000_5678);
      wr(8'h00, 32'hDEAD_0100);
      rd(8'h00, v); check("R3 pval mask", v, 32'h0000_0100);
      // R4 decrement per clock
      repeat (3) @(negedge clk);
      rd(8'h00, v); check("R4 pval countdown", v, 32'h0000_00FD);
      wr(8'h04, 32'h0);
      wr(8'h00, 32'h0);

      // R5 register windows
      wr(8'h10, 32'h0000_1234);
      rd(8'h10, v); check("R5 ch0 counter", v, 32'h0000_1234);
      wr(8'h24, 32'hCAFE_F00D);
      rd(8'h24, v); check("R5 ch1 reload", v, 32'hCAFE_F00D);

      // R6 undefined / nonexistent / unaligned
      wr(8'h40, 32'h55);
      wr(8'h48, 32'h0F);
      wr(8'h11, 32'h99);
      wr(8'h0C, 32'h77);
      rd(8'h40, v); check("R6 nonexistent ch read", v, 0);
      rd(8'h48, v); check("R6 nonexistent ctl read", v, 0);
      rd(8'h0C, v); check("R6 unit gap read", v, 0);
      rd(8'h1C, v); check("R6 ch gap read", v, 0);
      rd(8'h12, v); check("R6 unaligned read", v, 0);
      rd(8'h10, v); check("R6 ch0 untouched", v, 32'h0000_1234);
      check("R6 irq quiet", 32'(irq), 0);

      // R7 load bit and control readback
      wr(8'h28, 32'h0000_0004);
      rd(8'h20, v); check("R7 load copies reload", v, 32'hCAFE_F00D);
      rd(8'h28, v); check("R7 load reads zero", v, 0);
      wr(8'h28, 32'hFFFF_FF0A);
      rd(8'h28, v); check("R7 ctl readback", v, 32'h0000_000A);
      wr(8'h28, 32'h0);

      // R8/R9/R11 one-shot, K=5, tick every clock
      wr(8'h10, 32'd5);
      wr(8'h18, 32'h9);
      n = 0;
      while (irq[0] !== 1'b1 && n < 100) begin @(negedge clk); n++; end
      check("R8 underflow latency", 32'(n), 6);
      check("R11 only own line", 32'(irq), 32'h1);
      rd(8'h18, v); check("R9 enable cleared, pending set", v, 32'h18);
      @(negedge clk);
      check("R11 one-cycle pulse", 32'(irq), 0);
      wr(8'h18, 32'h08);
      rd(8'h18, v); check("R11 pending kept", v, 32'h18);
      wr(8'h18, 32'h18);
      rd(8'h18, v); check("R11 pending cleared", v, 32'h08);

      // R11 no interrupt when disabled
      wr(8'h10, 32'd2);
      wr(8'h18, 32'h1);
      repeat (10) @(negedge clk);
      check("R11 no irq without ie", 32'(irq), 0);
      rd(8'h18, v); check("R11 no pending without ie", v, 0);

      // R10 periodic sweep
      iso_bad = 1'b0;
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 4; k++) begin
            int ch;
            logic [7:0] base;
            ch = (p + k) % NCH;
            base = 8'(16 * (ch + 1));
            wr(8'h04, 32'(p));
            wr(base + 8'h4, 32'(k));
            wr(base + 8'h8, 32'h0F);
            n = 0;
            while (irq[ch] !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
            n = 0;
            do begin
               @(negedge clk); n++;
               if ((irq & ~(NCH'(1) << ch)) != '0) iso_bad = 1'b1;
            end while (irq[ch] !== 1'b1 && n < 1000);
            check($sformatf("R10 period p=%0d k=%0d", p, k), 32'(n), 32'((k + 1) * (p + 1)));
            wr(base + 8'h8, 32'h10);
            repeat (2) @(negedge clk);
         end
      end
      check("R11 lines isolated", 32'(iso_bad), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule